// File: doc/BRIEF.md
# Register-Programmed Single-Slave SPI Master

This block is a single-line SPI master for one serial flash or peripheral. A host drives it over a plain 32-bit word bus with write and read strobes, a byte address and read data that is valid in the same cycle. To run a flash operation, software queues every byte of the operation into a transmit queue: the opcode, the address bytes and any filler bytes. It then drives the chip-select register low and clears the start-inhibit bit. Once the exchange is over, it collects the returned bytes from a receive queue.

The exchange is full duplex. For each byte shifted out MSB-first, one byte is sampled back and queued, including the bytes that carry opcodes and addresses. The serial clock runs at half the block clock, in mode 0 (clock idles low) or mode 3 (clock idles high). In both modes data is sampled on the rising edge and changed on the falling edge. Chip select only changes when software writes its register. Occupancy registers report the count minus one. A sticky event register with per-bit enables and a global enable drives one interrupt line. Writing a key value to the reset register returns the whole block to its reset state in one cycle.

Top module: `spiq_master`

## Requirements
- R1: After reset: control reads 0x180, status reads 0x05, chip select is high, SCK is low, and both occupancy registers read 0.
- R2: A write of exactly 0x0000000A to offset 0x40 returns every register and both queues to the reset state at that clock edge, with nothing to undo afterwards. A write of any other value to 0x40 has no effect.
- R3: Offsets 0x74 and 0x78 read the transmit and receive entry counts minus one (six queued bytes read 5), and read 0 when the queue is empty.
- R4: Control at 0x60 holds spi-enable (bit 1), master (bit 2), clock-idle-high/mode 3 (bit 3), a stored manual-select bit (bit 7) and start-inhibit (bit 8). Queued bytes begin shifting only while enable=1, master=1 and inhibit=0 (0x86 starts them, 0x186 holds them).
- R5: Bytes are sent MSB first. SCK has a period of two block clocks, MOSI changes only on SCK falling edges or at byte load, bytes follow one another with no gap, and MOSI idles high.
- R6: Each transmitted byte produces exactly one received byte, sampled MSB first from MISO on SCK rising edges, and readable in order at 0x6C.
- R7: A received byte that arrives while the receive queue holds DEPTH entries is dropped, the older entries are kept, and event bit 1 (overrun) is set.
- R8: Chip select follows bit 0 of the register at 0x70 (0 drives it low, 1 high) and never changes on its own during or after a transfer.
- R9: Writing control bits 5 and 6 (e.g. 0x1E6) empties the transmit and receive queues. These two bits self-clear and read back as 0.
- R10: With bit 3 set, SCK idles high, and rising-edge sampling is unchanged.
- R11: Status at 0x64: bit 0 receive empty, bit 1 receive full, bit 2 transmit empty, bit 3 transmit full, bit 4 shifter busy.
- R12: Event register 0x20 holds bit 0 transfer done, bit 1 receive overrun, bit 2 transmit overflow and bit 3 receive queue full. Its bits are sticky and cleared by writing 1s. The irq output is high when bit 31 of 0x1C is set and an event bit is set whose enable in 0x28 is set.
- R13: A transmit write while the queue holds DEPTH entries is dropped and sets event bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; SCK is half of it |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive queue at 0x6C) |
| bus_addr | input | 7 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the strobe |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low chip select |
| irq | output | 1 | Level interrupt |

## Verification
A register write takes effect at the clock edge that samples it. A read returns data in its own cycle, and a receive read pops at the end of that cycle. Once a byte is loaded, SCK and MOSI move on every block clock. The received byte reaches the queue at the sixteenth edge after the load, and the next byte loads at that same edge. The bench steps a queue-based model at every rising edge from the same inputs and compares SCK, MOSI, chip select and irq at every falling edge. It samples register reads a short delay after the falling edge on which the strobe was driven, so each result is checked in the cycle it is due.

// File: rtl/spiq_pkg.sv
package spiq_pkg;
  localparam logic [6:0] A_GIE  = 7'h1C;
  localparam logic [6:0] A_ISR  = 7'h20;
  localparam logic [6:0] A_IER  = 7'h28;
  localparam logic [6:0] A_RST  = 7'h40;
  localparam logic [6:0] A_CTL  = 7'h60;
  localparam logic [6:0] A_STS  = 7'h64;
  localparam logic [6:0] A_TXD  = 7'h68;
  localparam logic [6:0] A_RXD  = 7'h6C;
  localparam logic [6:0] A_SS   = 7'h70;
  localparam logic [6:0] A_TXO  = 7'h74;
  localparam logic [6:0] A_RXO  = 7'h78;

  localparam logic [31:0] RESET_KEY = 32'h0000_000A;

  localparam int C_SPE   = 1;
  localparam int C_MST   = 2;
  localparam int C_CPOL  = 3;
  localparam int C_TXCLR = 5;
  localparam int C_RXCLR = 6;
  localparam int C_MAN   = 7;
  localparam int C_INH   = 8;

  localparam int EV_DONE = 0;
  localparam int EV_OVR  = 1;
  localparam int EV_TXOF = 2;
  localparam int EV_RXF  = 3;
  localparam int EV_N    = 4;

  typedef struct packed {
    logic inhibit;
    logic manual;
    logic cpol;
    logic master;
    logic spe;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{inhibit: 1'b1, manual: 1'b1, cpol: 1'b0,
                                 master: 1'b0, spe: 1'b0};
endpackage

// File: rtl/spiq_fifo.sv
module spiq_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic [$clog2(DEPTH):0] count,
  output logic             empty,
  output logic             full
);
  localparam int CW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW:0]   cnt_q, cnt_d;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (clr) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (push) wp_d = wp_q + 1'b1;
      if (pop)  rp_d = rp_q + 1'b1;
      cnt_d = cnt_q + {{CW{1'b0}}, push} - {{CW{1'b0}}, pop};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clr && !full) mem[wp_q] <= din;
  end

  assign dout  = mem[rp_q];
  assign count = cnt_q;
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == (CW+1)'(DEPTH));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && push && !pop) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/spiq_shift.sv
module spiq_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       go,
  input  logic       cpol,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       tx_pop,
  output logic       rx_push,
  output logic [7:0] rx_byte,
  output logic       done_evt,
  output logic       busy,
  output logic       sck,
  output logic       mosi
);
  logic       busy_q, busy_d;
  logic [3:0] ph_q, ph_d;
  logic [7:0] sh_q, sh_d;
  logic [7:0] rx_q, rx_d;
  logic       last, load;

  assign last = busy_q && (ph_q == 4'd15);
  assign load = go && (!busy_q || (ph_q == 4'd15));

  always_comb begin
    busy_d = busy_q;
    ph_d   = ph_q;
    sh_d   = sh_q;
    rx_d   = rx_q;
    if (clr) begin
      busy_d = 1'b0;
      ph_d   = '0;
      sh_d   = '0;
      rx_d   = '0;
    end else begin
      if (busy_q) begin
        ph_d = ph_q + 1'b1;
        if (!ph_q[0]) rx_d = {rx_q[6:0], miso};
        else          sh_d = {sh_q[6:0], 1'b0};
      end
      if (last) busy_d = 1'b0;
      if (load) begin
        busy_d = 1'b1;
        ph_d   = '0;
        sh_d   = tx_byte;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ph_q   <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
    end else begin
      busy_q <= busy_d;
      ph_q   <= ph_d;
      sh_q   <= sh_d;
      rx_q   <= rx_d;
    end
  end

  assign tx_pop   = load && !clr;
  assign rx_push  = last && !clr;
  assign rx_byte  = rx_q;
  assign done_evt = last && !load && !clr;
  assign busy     = busy_q;
  assign sck      = busy_q ? ph_q[0] : cpol;
  assign mosi     = busy_q ? sh_q[7] : 1'b1;

  // R5
  mosi_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> $stable(mosi));

  // R6
  one_rx_per_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> !rx_push);
endmodule

// File: rtl/spiq_master.sv
module spiq_master
  import spiq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [6:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        spi_sck,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic        spi_cs_n,
  output logic        irq
);
  localparam int CW = $clog2(DEPTH);

  ctrl_t           ctrl_q, ctrl_d;
  logic            ss_q, ss_d;
  logic            gie_q, gie_d;
  logic [EV_N-1:0] ier_q, ier_d;
  logic [EV_N-1:0] isr_q, isr_d, ev_set;

  logic clr_all, wr_ctl;
  logic tx_push, tx_pop, tx_empty, tx_full, tx_clr;
  logic rx_push, rx_pop, rx_empty, rx_full, rx_clr;
  logic [7:0] tx_dout, rx_dout, rx_byte;
  logic [CW:0] tx_cnt, rx_cnt, tx_occ, rx_occ;
  logic sh_push, sh_done, sh_busy, go;

  assign clr_all = bus_wr && (bus_addr == A_RST) && (bus_wdata == RESET_KEY);
  assign wr_ctl  = bus_wr && (bus_addr == A_CTL);

  assign tx_clr  = clr_all || (wr_ctl && bus_wdata[C_TXCLR]);
  assign rx_clr  = clr_all || (wr_ctl && bus_wdata[C_RXCLR]);
  assign tx_push = bus_wr && (bus_addr == A_TXD) && !tx_full;
  assign rx_push = sh_push && !rx_full;
  assign rx_pop  = bus_rd && (bus_addr == A_RXD) && !rx_empty;

  assign go = ctrl_q.spe && ctrl_q.master && !ctrl_q.inhibit && !tx_empty;

  spiq_fifo #(.DEPTH(DEPTH), .W(8)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr),
    .push(tx_push), .din(bus_wdata[7:0]),
    .pop(tx_pop), .dout(tx_dout),
    .count(tx_cnt), .empty(tx_empty), .full(tx_full)
  );

  spiq_fifo #(.DEPTH(DEPTH), .W(8)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr),
    .push(rx_push), .din(rx_byte),
    .pop(rx_pop), .dout(rx_dout),
    .count(rx_cnt), .empty(rx_empty), .full(rx_full)
  );

  spiq_shift u_shift (
    .clk(clk), .rst_n(rst_n), .clr(clr_all),
    .go(go), .cpol(ctrl_q.cpol), .tx_byte(tx_dout), .miso(spi_miso),
    .tx_pop(tx_pop), .rx_push(sh_push), .rx_byte(rx_byte),
    .done_evt(sh_done), .busy(sh_busy),
    .sck(spi_sck), .mosi(spi_mosi)
  );

  always_comb begin
    ev_set          = '0;
    ev_set[EV_DONE] = sh_done;
    ev_set[EV_OVR]  = sh_push && rx_full;
    ev_set[EV_TXOF] = bus_wr && (bus_addr == A_TXD) && tx_full;
    ev_set[EV_RXF]  = rx_full;
  end

  always_comb begin
    ctrl_d = ctrl_q;
    ss_d   = ss_q;
    gie_d  = gie_q;
    ier_d  = ier_q;
    isr_d  = isr_q;
    if (clr_all) begin
      ctrl_d = CTRL_RST;
      ss_d   = 1'b1;
      gie_d  = 1'b0;
      ier_d  = '0;
      isr_d  = '0;
    end else begin
      if (wr_ctl) begin
        ctrl_d.spe     = bus_wdata[C_SPE];
        ctrl_d.master  = bus_wdata[C_MST];
        ctrl_d.cpol    = bus_wdata[C_CPOL];
        ctrl_d.manual  = bus_wdata[C_MAN];
        ctrl_d.inhibit = bus_wdata[C_INH];
      end
      if (bus_wr && (bus_addr == A_SS))  ss_d  = bus_wdata[0];
      if (bus_wr && (bus_addr == A_GIE)) gie_d = bus_wdata[31];
      if (bus_wr && (bus_addr == A_IER)) ier_d = bus_wdata[EV_N-1:0];
      if (bus_wr && (bus_addr == A_ISR)) isr_d = isr_q & ~bus_wdata[EV_N-1:0];
      isr_d = isr_d | ev_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      ss_q   <= 1'b1;
      gie_q  <= 1'b0;
      ier_q  <= '0;
      isr_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      ss_q   <= ss_d;
      gie_q  <= gie_d;
      ier_q  <= ier_d;
      isr_q  <= isr_d;
    end
  end

  assign tx_occ = tx_empty ? '0 : tx_cnt - 1'b1;
  assign rx_occ = rx_empty ? '0 : rx_cnt - 1'b1;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_GIE: bus_rdata[31] = gie_q;
      A_ISR: bus_rdata[EV_N-1:0] = isr_q;
      A_IER: bus_rdata[EV_N-1:0] = ier_q;
      A_CTL: begin
        bus_rdata[C_SPE]  = ctrl_q.spe;
        bus_rdata[C_MST]  = ctrl_q.master;
        bus_rdata[C_CPOL] = ctrl_q.cpol;
        bus_rdata[C_MAN]  = ctrl_q.manual;
        bus_rdata[C_INH]  = ctrl_q.inhibit;
      end
      A_STS: bus_rdata[4:0] = {sh_busy, tx_full, tx_empty, rx_full, rx_empty};
      A_RXD: bus_rdata[7:0] = rx_empty ? 8'h00 : rx_dout;
      A_SS:  bus_rdata[0] = ss_q;
      A_TXO: bus_rdata[CW:0] = tx_occ;
      A_RXO: bus_rdata[CW:0] = rx_occ;
      default: bus_rdata = '0;
    endcase
  end

  assign spi_cs_n = ss_q;
  assign irq      = gie_q && |(isr_q & ier_q);

  // R4
  inhibit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.inhibit && !sh_busy) |=> !sh_busy);

  // R8
  cs_static_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spi_cs_n) |-> $past(bus_wr && ((bus_addr == A_SS) || (bus_addr == A_RST))));

  // R12
  isr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_q[EV_OVR] && !clr_all && !(bus_wr && (bus_addr == A_ISR) && bus_wdata[EV_OVR]))
      |=> isr_q[EV_OVR]);
endmodule

// File: tb/spiq_master_tb.sv
module spiq_master_tb;
  localparam int CLK_P = 10;
  localparam int DEPTH = 16;

  logic clk, rst_n, bus_wr, bus_rd, inv, cmp_en;
  logic [6:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic spi_sck, spi_mosi, spi_miso, spi_cs_n, irq;
  int vectors, fails;

  assign spi_miso = spi_mosi ^ inv;

  spiq_master #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // behavioural reference model
  logic [7:0] q_tx[$], q_rx[$];
  bit m_spe, m_mst, m_cpol, m_man, m_inh, m_ss, m_gie, m_busy;
  bit [3:0] m_ier, m_isr;
  int m_ph;
  logic [7:0] m_cur;

  task automatic m_reset();
    q_tx.delete(); q_rx.delete();
    m_spe = 0; m_mst = 0; m_cpol = 0; m_man = 1; m_inh = 1; m_ss = 1;
    m_gie = 0; m_ier = 0; m_isr = 0; m_busy = 0; m_ph = 0; m_cur = 0;
  endtask

  task automatic m_step();
    int ntx = q_tx.size();
    int nrx = q_rx.size();
    bit [3:0] setb = 0;
    bit go, last, load;
    if (bus_wr && bus_addr == 7'h40 && bus_wdata == 32'hA) begin
      m_reset();
      return;
    end
    go   = m_spe && m_mst && !m_inh && ntx > 0;
    last = m_busy && m_ph == 15;
    load = go && (!m_busy || m_ph == 15);
    if (bus_rd && bus_addr == 7'h6C && nrx > 0) void'(q_rx.pop_front());
    if (last) begin
      if (nrx < DEPTH) q_rx.push_back(m_cur ^ {8{inv}});
      else setb[1] = 1;
      if (!load) setb[0] = 1;
    end
    if (nrx == DEPTH) setb[3] = 1;
    if (m_busy) m_ph++;
    if (last) m_busy = 0;
    if (load) begin m_cur = q_tx.pop_front(); m_busy = 1; m_ph = 0; end
    if (bus_wr) begin
      case (bus_addr)
        7'h1C: m_gie = bus_wdata[31];
        7'h20: m_isr = m_isr & ~bus_wdata[3:0];
        7'h28: m_ier = bus_wdata[3:0];
        7'h60: begin
          m_spe = bus_wdata[1]; m_mst = bus_wdata[2]; m_cpol = bus_wdata[3];
          m_man = bus_wdata[7]; m_inh = bus_wdata[8];
          if (bus_wdata[5]) q_tx.delete();
          if (bus_wdata[6]) q_rx.delete();
        end
        7'h68: if (ntx < DEPTH) q_tx.push_back(bus_wdata[7:0]); else setb[2] = 1;
        7'h70: m_ss = bus_wdata[0];
        default: ;
      endcase
    end
    m_isr = m_isr | setb;
  endtask

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else m_step();
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // per-clock pin comparison against the model
  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R5 sck", {31'b0, spi_sck}, {31'b0, m_busy ? m_ph[0] : m_cpol});
      chk("R5 mosi", {31'b0, spi_mosi}, {31'b0, m_busy ? m_cur[7 - m_ph/2] : 1'b1});
      chk("R8 cs_n", {31'b0, spi_cs_n}, {31'b0, m_ss});
      chk("R12 irq", {31'b0, irq}, {31'b0, m_gie && |(m_isr & m_ier)});
    end
  end

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic rchk(string tag, logic [6:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic wait_quiet();
    @(negedge clk);
    while (m_busy || (m_spe && m_mst && !m_inh && q_tx.size() > 0)) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [7:0] pat[6];
    vectors = 0; fails = 0; cmp_en = 0; inv = 0;
    bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1;
    #1 rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cmp_en = 1;

    // R1 reset state
    rchk("R1 ctrl", 7'h60, 32'h180);
    rchk("R1 R11 status", 7'h64, 32'h05);
    chk("R1 cs_n", {31'b0, spi_cs_n}, 32'h1);
    chk("R1 sck", {31'b0, spi_sck}, 32'h0);
    rchk("R1 txocc", 7'h74, 32'h0);
    rchk("R1 rxocc", 7'h78, 32'h0);

    // R9 fifo reset bits self-clear
    wr(7'h60, 32'h1E6);
    rchk("R9 ctrl readback", 7'h60, 32'h186);
    pat = '{8'h9F, 8'h12, 8'h34, 8'h56, 8'h78, 8'hA5};
    foreach (pat[i]) wr(7'h68, {24'b0, pat[i]});
    rchk("R3 txocc six", 7'h74, 32'd5);
    rchk("R11 status queued", 7'h64, 32'h01);

    // R8 chip select, R4 inhibit holds bytes
    wr(7'h70, 32'h0);
    chk("R8 cs low", {31'b0, spi_cs_n}, 32'h0);
    repeat (40) @(negedge clk);
    rchk("R4 inhibit txocc", 7'h74, 32'd5);
    chk("R4 sck idle", {31'b0, spi_sck}, 32'h0);

    // R4 start, R5/R6 full duplex loopback
    wr(7'h60, 32'h86);
    wait_quiet();
    chk("R8 cs held", {31'b0, spi_cs_n}, 32'h0);
    rchk("R3 R6 rxocc", 7'h78, 32'd5);
    foreach (pat[i]) rchk("R6 rx byte", 7'h6C, {24'b0, pat[i]});
    rchk("R11 status drained", 7'h64, 32'h05);
    wr(7'h70, 32'h1);
    chk("R8 cs high", {31'b0, spi_cs_n}, 32'h1);

    // R6 inverted MISO
    inv = 1;
    wr(7'h68, 32'h3C);
    wr(7'h68, 32'h81);
    wait_quiet();
    rchk("R6 inv rx0", 7'h6C, 32'hC3);
    rchk("R6 inv rx1", 7'h6C, 32'h7E);
    inv = 0;

    // R10 mode 3
    wr(7'h60, 32'h18E);
    chk("R10 sck idle high", {31'b0, spi_sck}, 32'h1);
    wr(7'h68, 32'h5A);
    wr(7'h60, 32'h8E);
    wait_quiet();
    chk("R10 sck idle after", {31'b0, spi_sck}, 32'h1);
    rchk("R10 rx", 7'h6C, 32'h5A);

    // R7 receive overrun
    wr(7'h20, 32'hF);
    wr(7'h60, 32'h1E6);
    for (int i = 0; i < DEPTH; i++) wr(7'h68, i * 3 + 1);
    wr(7'h60, 32'h86);
    wait_quiet();
    wr(7'h68, 32'hEE);
    wr(7'h68, 32'hDD);
    wait_quiet();
    rchk("R7 rxocc full", 7'h78, DEPTH - 1);
    rchk("R11 status rxfull", 7'h64, 32'h06);
    rchk("R7 R12 isr", 7'h20, 32'hB);
    rchk("R7 oldest kept", 7'h6C, 32'h01);
    wr(7'h20, 32'h2);
    rchk("R12 w1c one bit", 7'h20, 32'h9);
    wr(7'h20, 32'hF);
    rchk("R12 cleared", 7'h20, 32'h0);

    // R13 transmit overflow
    wr(7'h60, 32'h1E6);
    rchk("R9 rx emptied", 7'h78, 32'h0);
    for (int i = 0; i < DEPTH + 1; i++) wr(7'h68, 32'h40 + i);
    rchk("R13 txocc", 7'h74, DEPTH - 1);
    rchk("R11 R13 status", 7'h64, 32'h09);
    rchk("R13 isr", 7'h20, 32'h4);

    // R12 interrupt gating
    wr(7'h28, 32'h4);
    chk("R12 irq no gie", {31'b0, irq}, 32'h0);
    wr(7'h1C, 32'h8000_0000);
    chk("R12 irq on", {31'b0, irq}, 32'h1);
    wr(7'h20, 32'h4);
    chk("R12 irq cleared", {31'b0, irq}, 32'h0);

    // R2 soft reset
    wr(7'h40, 32'h5);
    rchk("R2 wrong key ctrl", 7'h60, 32'h186);
    rchk("R2 wrong key txocc", 7'h74, DEPTH - 1);
    wr(7'h40, 32'hA);
    rchk("R2 ctrl", 7'h60, 32'h180);
    rchk("R2 txocc", 7'h74, 32'h0);
    rchk("R2 status", 7'h64, 32'h05);
    rchk("R2 ier", 7'h28, 32'h0);
    rchk("R2 gie", 7'h1C, 32'h0);
    chk("R2 cs_n", {31'b0, spi_cs_n}, 32'h1);

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule